// File: doc/BRIEF.md
# Configuration Access Port with Security Lock

This block is the test and configuration port of a fuse-programmed logic device. A host sends one command per handshake: write or verify-read a word of the configuration fuse array, write or read a byte of an eight-byte user signature, force a single macrocell register to 1 or 0, set the security lock, or erase everything. Each command produces exactly one response beat that carries read data and an error flag.

The security lock cuts off fuse verify reads and register preload on the very next command after the one that sets it. The user signature stays fully usable whether the lock is set or not. Only the erase command clears the lock, and it wipes the fuse array in the same step. Signature bytes and macrocell registers are left as they were by an erase.

Both sides of the port use valid/ready. A command is taken on a cycle where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low whenever a response is waiting. It is also low for the single commit cycle that follows any state-changing command. A response is held, with its data and flag stable, until `rsp_ready` takes it. While a response is waiting, the port accepts no new command, so a host that never raises `rsp_ready` stalls the port.

Top module: `cfg_access_port`

## Requirements
- R1: After reset, `cmd_ready` is 1, `rsp_valid` is 0, `secured` is 0, `mc_q` is all zeros, and every fuse word and signature byte reads 0.
- R2: A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both high. The write-type opcodes are 1 (fuse write), 3 (signature write), 5 (preload), 6 (secure) and 7 (erase). After one of them is accepted, the next cycle shows `cmd_ready` low and `rsp_valid` low, and the response appears one cycle later. The read opcodes 2 and 4, and opcode 0, respond in the cycle right after acceptance.
- R3: A response stays valid with stable `rsp_data` and `rsp_err` until `rsp_ready` is high at a clock edge. While a response is waiting, no command is accepted.
- R4: With the lock clear, opcode 1 stores `cmd_wdata` at fuse word `cmd_addr`, and opcode 2 returns it with `rsp_err` 0. A fuse address at or beyond FUSE_WORDS gives `rsp_err` 1 and data 0, and a write to such an address changes nothing.
- R5: With the lock set, opcode 2 returns data 0 with `rsp_err` 1 at every address.
- R6: Opcode 3 writes `cmd_wdata[7:0]` to signature byte `cmd_addr` (0..7), and opcode 4 reads it back with `rsp_err` 0, whether the lock is set or clear. An address of 8 or more gives `rsp_err` 1.
- R7: With the lock clear, opcode 5 loads `cmd_wdata[0]` into `mc_q[cmd_addr]` and leaves every other bit unchanged. An index at or beyond NUM_MC gives `rsp_err` 1 and leaves `mc_q` unchanged.
- R8: With the lock set, opcode 5 gives `rsp_err` 1 and leaves `mc_q` unchanged.
- R9: Opcode 6 responds with `rsp_err` 0 and raises `secured`. The next command accepted after it already sees the lock.
- R10: Opcode 7 clears `secured` and every fuse word, responds with `rsp_err` 0, and keeps the signature and `mc_q`.
- R11: Opcode 0 responds with `rsp_err` 1 and changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Port can take a command |
| cmd_op | input | 3 | Opcode |
| cmd_addr | input | ADDR_W | Fuse word, signature byte or macrocell index |
| cmd_wdata | input | WORD_W | Write data; bit 0 is the preload value |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Host takes the response |
| rsp_data | output | WORD_W | Read data, 0 for write-type commands |
| rsp_err | output | 1 | Command refused or out of range |
| secured | output | 1 | Security lock state |
| mc_q | output | NUM_MC | Macrocell register values |

## Verification
The hardest case to reach is the window where the lock has just been set. The command right behind the secure command must already be refused, with no extra cycle of access. The bench issues a fuse verify read as the very next command after the secure response. It then sweeps every fuse address and every preload index while locked, and checks that signature reads still return the stored bytes. Response back-pressure is exercised by holding `rsp_ready` low while a second command is held valid. That command must not land in the signature store, and the bench confirms this by reading the byte back.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_FUSE_WR = 3'd1,
    OP_FUSE_RD = 3'd2,
    OP_SIG_WR  = 3'd3,
    OP_SIG_RD  = 3'd4,
    OP_PRELOAD = 3'd5,
    OP_SECURE  = 3'd6,
    OP_ERASE   = 3'd7
  } op_e;

  typedef enum logic {ST_IDLE = 1'b0, ST_COMMIT = 1'b1} st_e;

  // Opcodes that change state and therefore take a commit cycle.
  function automatic logic op_commits(input logic [2:0] op);
    return (op == OP_FUSE_WR) || (op == OP_SIG_WR) || (op == OP_PRELOAD) ||
           (op == OP_SECURE) || (op == OP_ERASE);
  endfunction
endpackage

// File: rtl/cfg_word_store.sv
module cfg_word_store #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             clr,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            mem[i] <= '0;
      else if (clr)                          mem[i] <= '0;
      else if (we && (waddr == AW'(i)))      mem[i] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (raddr == AW'(k)) rdata = mem[k];
    end
  end
endmodule

// File: rtl/cfg_preload_bank.sv
module cfg_preload_bank #(
  parameter int NUM_MC = 10,
  localparam int IW = (NUM_MC > 1) ? $clog2(NUM_MC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [IW-1:0]     ld_idx,
  input  logic              ld_val,
  output logic [NUM_MC-1:0] q
);
  for (genvar i = 0; i < NUM_MC; i++) begin : g_mc
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          q[i] <= 1'b0;
      else if (ld_en && ld_idx == IW'(i))  q[i] <= ld_val;
    end
  end
endmodule

// File: rtl/cfg_access_port.sv
module cfg_access_port
  import cfg_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int WORD_W     = 8,
  parameter int FUSE_WORDS = 16,
  parameter int SIG_BYTES  = 8,
  parameter int NUM_MC     = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [WORD_W-1:0] cmd_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [WORD_W-1:0] rsp_data,
  output logic              rsp_err,
  output logic              secured,
  output logic [NUM_MC-1:0] mc_q
);
  localparam int FUSE_AW = (FUSE_WORDS > 1) ? $clog2(FUSE_WORDS) : 1;
  localparam int SIG_AW  = (SIG_BYTES > 1) ? $clog2(SIG_BYTES) : 1;
  localparam int MC_AW   = (NUM_MC > 1) ? $clog2(NUM_MC) : 1;
  localparam logic [ADDR_W-1:0] FUSE_LIM = ADDR_W'(FUSE_WORDS);
  localparam logic [ADDR_W-1:0] SIG_LIM  = ADDR_W'(SIG_BYTES);
  localparam logic [ADDR_W-1:0] MC_LIM   = ADDR_W'(NUM_MC);

  st_e               state_q;
  logic [2:0]        op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] data_q;
  logic              lock_q;
  logic              rsp_v_q, rsp_e_q;
  logic [WORD_W-1:0] rsp_d_q;
  logic [2:0]        rsp_op_q;

  logic accept, in_commit;
  logic fuse_we, fuse_clr, sig_we, mc_ld;
  logic addr_q_fuse_ok, addr_q_sig_ok, addr_q_mc_ok;
  logic cmd_fuse_ok, cmd_sig_ok;
  logic [WORD_W-1:0] fuse_rd;
  logic [7:0]        sig_rd;
  logic [WORD_W-1:0] rd_data_c;
  logic              rd_err_c, commit_err_c;

  assign cmd_ready = (state_q == ST_IDLE) && !rsp_v_q;
  assign accept    = cmd_valid && cmd_ready;
  assign in_commit = (state_q == ST_COMMIT);

  assign addr_q_fuse_ok = addr_q < FUSE_LIM;
  assign addr_q_sig_ok  = addr_q < SIG_LIM;
  assign addr_q_mc_ok   = addr_q < MC_LIM;
  assign cmd_fuse_ok    = cmd_addr < FUSE_LIM;
  assign cmd_sig_ok     = cmd_addr < SIG_LIM;

  // Commit-cycle write enables
  assign fuse_we  = in_commit && (op_q == OP_FUSE_WR) && addr_q_fuse_ok;
  assign fuse_clr = in_commit && (op_q == OP_ERASE);
  assign sig_we   = in_commit && (op_q == OP_SIG_WR) && addr_q_sig_ok;
  assign mc_ld    = in_commit && (op_q == OP_PRELOAD) && addr_q_mc_ok && !lock_q;

  cfg_word_store #(.DEPTH(FUSE_WORDS), .WIDTH(WORD_W)) u_fuse (
    .clk(clk), .rst_n(rst_n),
    .we(fuse_we), .waddr(addr_q[FUSE_AW-1:0]), .wdata(data_q),
    .clr(fuse_clr),
    .raddr(cmd_addr[FUSE_AW-1:0]), .rdata(fuse_rd)
  );

  cfg_word_store #(.DEPTH(SIG_BYTES), .WIDTH(8)) u_sig (
    .clk(clk), .rst_n(rst_n),
    .we(sig_we), .waddr(addr_q[SIG_AW-1:0]), .wdata(data_q[7:0]),
    .clr(1'b0),
    .raddr(cmd_addr[SIG_AW-1:0]), .rdata(sig_rd)
  );

  cfg_preload_bank #(.NUM_MC(NUM_MC)) u_mc (
    .clk(clk), .rst_n(rst_n),
    .ld_en(mc_ld), .ld_idx(addr_q[MC_AW-1:0]), .ld_val(data_q[0]),
    .q(mc_q)
  );

  // Immediate read response
  always_comb begin
    rd_data_c = '0;
    rd_err_c  = 1'b1;
    case (cmd_op)
      OP_FUSE_RD: begin
        if (cmd_fuse_ok && !lock_q) begin
          rd_data_c = fuse_rd;
          rd_err_c  = 1'b0;
        end
      end
      OP_SIG_RD: begin
        if (cmd_sig_ok) begin
          rd_data_c = WORD_W'(sig_rd);
          rd_err_c  = 1'b0;
        end
      end
      default: rd_err_c = 1'b1;
    endcase
  end

  // Error flag of a committing command
  always_comb begin
    case (op_q)
      OP_FUSE_WR: commit_err_c = !addr_q_fuse_ok;
      OP_SIG_WR:  commit_err_c = !addr_q_sig_ok;
      OP_PRELOAD: commit_err_c = !addr_q_mc_ok || lock_q;
      default:    commit_err_c = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      op_q     <= '0;
      addr_q   <= '0;
      data_q   <= '0;
      lock_q   <= 1'b0;
      rsp_v_q  <= 1'b0;
      rsp_e_q  <= 1'b0;
      rsp_d_q  <= '0;
      rsp_op_q <= '0;
    end else begin
      if (rsp_v_q && rsp_ready) rsp_v_q <= 1'b0;
      if (state_q == ST_IDLE) begin
        if (accept) begin
          if (op_commits(cmd_op)) begin
            state_q <= ST_COMMIT;
            op_q    <= cmd_op;
            addr_q  <= cmd_addr;
            data_q  <= cmd_wdata;
          end else begin
            rsp_v_q  <= 1'b1;
            rsp_d_q  <= rd_data_c;
            rsp_e_q  <= rd_err_c;
            rsp_op_q <= cmd_op;
          end
        end
      end else begin
        state_q  <= ST_IDLE;
        rsp_v_q  <= 1'b1;
        rsp_d_q  <= '0;
        rsp_e_q  <= commit_err_c;
        rsp_op_q <= op_q;
        if (op_q == OP_SECURE)     lock_q <= 1'b1;
        else if (op_q == OP_ERASE) lock_q <= 1'b0;
      end
    end
  end

  assign rsp_valid = rsp_v_q;
  assign rsp_data  = rsp_d_q;
  assign rsp_err   = rsp_e_q;
  assign secured   = lock_q;

  // R2: a state-changing command blocks the port for its commit cycle
  p_commit_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op_commits(cmd_op)) |=> (!cmd_ready && !rsp_valid));

  // R3: a waiting response holds its contents
  p_rsp_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_err)));

  // R5: locked verify reads return nothing
  p_locked_verify_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_op_q == OP_FUSE_RD && secured) |-> (rsp_data == '0 && rsp_err));

  // R8: locked preload never moves the macrocell registers
  p_locked_preload_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_commit && op_q == OP_PRELOAD && secured) |=> $stable(mc_q));

  // R9: the lock only falls through an erase
  p_lock_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (secured && !(in_commit && op_q == OP_ERASE)) |=> secured);

  // R10: erase drops the lock
  p_erase_unlocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_commit && op_q == OP_ERASE) |=> !secured);
endmodule

// File: tb/cfg_access_port_tb.sv
module cfg_access_port_tb_top;
  localparam int FUSE_WORDS = 16;
  localparam int SIG_BYTES  = 8;
  localparam int NUM_MC     = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_op = '0;
  logic [7:0]  cmd_addr = '0;
  logic [7:0]  cmd_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [7:0]  rsp_data;
  logic        rsp_err;
  logic        secured;
  logic [NUM_MC-1:0] mc_q;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  cfg_access_port dut_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .rsp_err(rsp_err),
    .secured(secured), .mc_q(mc_q)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] fuse_pat(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  function automatic logic [7:0] sig_pat(input int i);
    return 8'((i * 53 + 7) & 255);
  endfunction

  task automatic do_cmd(input logic [2:0] op, input logic [7:0] addr, input logic [7:0] wd,
                        output logic [7:0] rd, output logic er);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = addr; cmd_wdata = wd;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (op == 3'd1 || op == 3'd3 || op == 3'd5 || op == 3'd6 || op == 3'd7) begin
      // R2: commit cycle, port stalled and no response yet
      chk(!cmd_ready && !rsp_valid, "R2 commit stall", {cmd_ready, rsp_valid}, 0);
      @(negedge clk);
    end
    chk(rsp_valid, "R2 response timing", rsp_valid, 1);
    while (!rsp_valid) @(negedge clk);
    rd = rsp_data; er = rsp_err;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    logic er;
    logic [NUM_MC-1:0] mc_exp;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cmd_ready == 1'b1, "R1 cmd_ready", cmd_ready, 1);
    chk(rsp_valid == 1'b0, "R1 rsp_valid", rsp_valid, 0);
    chk(secured == 1'b0, "R1 secured", secured, 0);
    chk(mc_q == '0, "R1 mc_q", mc_q, 0);
    for (int i = 0; i < FUSE_WORDS; i++) begin
      do_cmd(3'd2, 8'(i), 8'h00, rd, er);
      chk(rd == 8'h00 && !er, "R1 fuse clear", rd, 0);
    end
    for (int i = 0; i < SIG_BYTES; i++) begin
      do_cmd(3'd4, 8'(i), 8'h00, rd, er);
      chk(rd == 8'h00 && !er, "R1 sig clear", rd, 0);
    end

    // R4 fuse sweep
    for (int i = 0; i < FUSE_WORDS; i++) begin
      do_cmd(3'd1, 8'(i), fuse_pat(i), rd, er);
      chk(!er, "R4 fuse write err", er, 0);
    end
    for (int i = FUSE_WORDS - 1; i >= 0; i--) begin
      do_cmd(3'd2, 8'(i), 8'h00, rd, er);
      chk(rd == fuse_pat(i) && !er, "R4 fuse readback", rd, fuse_pat(i));
    end
    do_cmd(3'd1, 8'd20, 8'hAA, rd, er);
    chk(er, "R4 write out of range err", er, 1);
    do_cmd(3'd2, 8'd4, 8'h00, rd, er);
    chk(rd == fuse_pat(4), "R4 alias untouched", rd, fuse_pat(4));
    do_cmd(3'd2, 8'd16, 8'h00, rd, er);
    chk(rd == 8'h00 && er, "R4 read out of range", {er, rd}, 9'h100);

    // R6 signature sweep
    for (int i = 0; i < SIG_BYTES; i++) do_cmd(3'd3, 8'(i), sig_pat(i), rd, er);
    for (int i = 0; i < SIG_BYTES; i++) begin
      do_cmd(3'd4, 8'(i), 8'h00, rd, er);
      chk(rd == sig_pat(i) && !er, "R6 sig readback", rd, sig_pat(i));
    end
    do_cmd(3'd4, 8'd8, 8'h00, rd, er);
    chk(er, "R6 sig out of range", er, 1);

    // R7 preload sweep
    mc_exp = '0;
    for (int i = 0; i < NUM_MC; i++) begin
      do_cmd(3'd5, 8'(i), 8'h01, rd, er);
      mc_exp[i] = 1'b1;
      chk(mc_q == mc_exp && !er, "R7 preload one", mc_q, mc_exp);
    end
    do_cmd(3'd5, 8'd3, 8'hFE, rd, er);
    mc_exp[3] = 1'b0;
    chk(mc_q == mc_exp && !er, "R7 preload zero", mc_q, mc_exp);
    do_cmd(3'd5, 8'd10, 8'h00, rd, er);
    chk(mc_q == mc_exp && er, "R7 index out of range", mc_q, mc_exp);

    // R11 opcode 0
    do_cmd(3'd0, 8'd2, 8'h55, rd, er);
    chk(er && mc_q == mc_exp && !secured, "R11 nop", {er, secured}, 2);
    do_cmd(3'd2, 8'd2, 8'h00, rd, er);
    chk(rd == fuse_pat(2), "R11 fuse untouched", rd, fuse_pat(2));

    // R3 back-pressure with a competing command held valid
    rsp_ready = 1'b0;
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd4; cmd_addr = 8'd5; cmd_wdata = 8'h00;
    @(negedge clk);
    cmd_op = 3'd3; cmd_addr = 8'd0; cmd_wdata = 8'hEE;
    for (int k = 0; k < 4; k++) begin
      chk(rsp_valid && !cmd_ready && rsp_data == sig_pat(5), "R3 hold", rsp_data, sig_pat(5));
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    rsp_ready = 1'b1;
    @(negedge clk);
    chk(!rsp_valid && cmd_ready, "R3 release", rsp_valid, 0);
    do_cmd(3'd4, 8'd0, 8'h00, rd, er);
    chk(rd == sig_pat(0), "R3 stalled command dropped", rd, sig_pat(0));

    // R9 lock takes effect on the next command
    do_cmd(3'd6, 8'd0, 8'h00, rd, er);
    chk(!er && secured, "R9 secure ack", {er, secured}, 1);
    do_cmd(3'd2, 8'd1, 8'h00, rd, er);
    chk(rd == 8'h00 && er, "R9 first read after lock", {er, rd}, 9'h100);
    for (int i = 0; i < FUSE_WORDS; i++) begin
      do_cmd(3'd2, 8'(i), 8'h00, rd, er);
      chk(rd == 8'h00 && er, "R5 locked verify", {er, rd}, 9'h100);
    end
    for (int i = 0; i < SIG_BYTES; i++) begin
      do_cmd(3'd4, 8'(i), 8'h00, rd, er);
      chk(rd == sig_pat(i) && !er, "R6 sig while locked", rd, sig_pat(i));
    end
    do_cmd(3'd3, 8'd7, 8'h3C, rd, er);
    do_cmd(3'd4, 8'd7, 8'h00, rd, er);
    chk(rd == 8'h3C && !er, "R6 sig write while locked", rd, 8'h3C);
    for (int i = 0; i < NUM_MC; i++) begin
      do_cmd(3'd5, 8'(i), {7'd0, ~mc_exp[i]}, rd, er);
      chk(er && mc_q == mc_exp, "R8 locked preload", mc_q, mc_exp);
    end

    // R10 erase
    do_cmd(3'd7, 8'd0, 8'h00, rd, er);
    chk(!er && !secured, "R10 erase ack", {er, secured}, 0);
    chk(mc_q == mc_exp, "R10 mc kept", mc_q, mc_exp);
    for (int i = 0; i < FUSE_WORDS; i++) begin
      do_cmd(3'd2, 8'(i), 8'h00, rd, er);
      chk(rd == 8'h00 && !er, "R10 fuse cleared", rd, 0);
    end
    do_cmd(3'd4, 8'd2, 8'h00, rd, er);
    chk(rd == sig_pat(2), "R10 sig kept", rd, sig_pat(2));
    do_cmd(3'd5, 8'd3, 8'h01, rd, er);
    mc_exp[3] = 1'b1;
    chk(!er && mc_q == mc_exp, "R10 preload reopened", mc_q, mc_exp);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule